// File: doc/BRIEF.md
# Sprite Line Candidate Scanner

During horizontal blanking this block walks the sprite attribute table in video memory. It finds the sprites whose vertical extent covers the scanline about to be drawn. Each read returns two neighbouring Y bytes, and both are judged in the same cycle. Every sprite that covers the line is recorded in a small slot list, with its table index and its Y value. A later stage uses that list to fetch X positions and pattern data.

The scan begins when a start pulse arrives at a fixed horizontal position. After that, the scanner issues one table read for each access-slot strobe. The scan stops at the first end-of-table Y value, after 64 entries have been examined, or when a covering sprite arrives after every slot is already taken. That last case raises a sticky overflow flag, which stays set until a status-clear pulse arrives.

Top module: `sprite_line_eval`

## Requirements
- R1: The target line is `line_i + 1` modulo 256. Line 255 therefore targets line 0.
- R2: On an accepted strobe the read address is `{tbl_base_i[6:1], 8'h00} + idx`, where `idx` is the even index of the pair. Read data arrives one cycle later: bits [7:0] hold the Y of entry `idx` and bits [15:8] hold the Y of entry `idx+1`. Only one read is outstanding at a time, and a strobe that arrives while a read is pending is ignored.
- R3: Sprite height is 16 lines when `tall_i` is 1 and 8 lines otherwise. A sprite covers the target line T when Y <= T < Y + height, with the sum taken without wrapping.
- R4: Covering sprites fill the slots from position NSLOT-1 downward in table order. Slot s reports its valid bit at `slot_vld_o[s]`, its 6-bit index at `slot_idx_o[6s+:6]` and its Y at `slot_y_o[8s+:8]`.
- R5: A Y value of 0xD0 or above ends the scan at that entry. If the first byte of a pair ends the scan, the second byte is ignored.
- R6: Exactly NSLOT (8) covering sprites do not raise overflow. A covering sprite that arrives with no free slot sets `overflow_o` and ends the scan.
- R7: `overflow_o` stays set until a `stat_clr_i` pulse arrives. A new scan does not clear it, and a set in the same cycle as a clear takes priority.
- R8: At most 64 entries, that is 32 reads, are examined per line. After the scan ends `scan_done_o` is 1, and strobes cause no reads.
- R9: `scan_start_i` restarts the scan from any state. On the next cycle the index is 0, every slot is invalid, all slots are free and `scan_done_o` is 0. A read still in flight is discarded.
- R10: After reset no slot is valid, overflow is 0, `scan_done_o` is 1 and no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| line_i | input | 8 | Current line counter |
| tbl_base_i | input | 7 | Attribute table base register |
| tall_i | input | 1 | Sprite height select (1 = 16 lines) |
| scan_start_i | input | 1 | Restart pulse for the line scan |
| scan_slot_i | input | 1 | Memory access slot strobe |
| stat_clr_i | input | 1 | Status read pulse that clears overflow |
| vram_rd_en_o | output | 1 | Table read request |
| vram_rd_addr_o | output | 14 | Table read address |
| vram_rd_data_i | input | 16 | Two Y bytes, valid one cycle after the request |
| slot_vld_o | output | 8 | Slot valid bits |
| slot_idx_o | output | 48 | Sprite index per slot |
| slot_y_o | output | 64 | Sprite Y per slot |
| overflow_o | output | 1 | Sticky per-line overflow |
| scan_done_o | output | 1 | Scan finished or idle |

## Verification
The assertions check several invariants on every cycle:
- the number of valid slots always equals NSLOT minus the free count;
- overflow rises only when the free count is zero, and it holds until cleared;
- reads are never issued back to back, are never issued when the scan is finished, and always use an even address;
- a terminating first byte suppresses both slot writes;
- a start leaves the scanner in its initial state.

Only the bench scenarios can show the rest, because it depends on table contents:
- which sprites cover a line at the 8- and 16-line boundaries and across the wrap at line 255;
- the downward fill order;
- the difference between exactly eight and nine covering sprites;
- the number of reads a table costs.

// File: rtl/sle_pkg.sv
package sle_pkg;

  localparam int VADDR_W = 14;
  localparam logic [7:0] TERM_Y = 8'hD0;

  typedef enum logic [1:0] {
    ST_DONE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } scan_state_e;

  function automatic logic [7:0] f_target_line(input logic [7:0] line);
    return line + 8'd1;
  endfunction

  function automatic logic [4:0] f_height(input logic tall);
    return tall ? 5'd16 : 5'd8;
  endfunction

  function automatic logic f_covers(input logic [7:0] y, input logic [7:0] t,
                                    input logic tall);
    logic [8:0] y_end;
    y_end = {1'b0, y} + {4'd0, f_height(tall)};
    return (y <= t) && ({1'b0, t} < y_end);
  endfunction

  function automatic logic f_is_term(input logic [7:0] y);
    return y >= TERM_Y;
  endfunction

  function automatic logic [VADDR_W-1:0] f_table_base(input logic [6:0] base_reg);
    return {base_reg[6:1], 8'h00};
  endfunction

endpackage

// File: rtl/sle_pair_eval.sv
module sle_pair_eval
  import sle_pkg::*;
#(
  parameter int NSLOT = 8,
  localparam int CNT_W = $clog2(NSLOT + 1),
  localparam int POS_W = $clog2(NSLOT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [7:0]       y0_i,
  input  logic [7:0]       y1_i,
  input  logic [7:0]       tline_i,
  input  logic             tall_i,
  input  logic [CNT_W-1:0] free_i,
  output logic             w0_o,
  output logic [POS_W-1:0] pos0_o,
  output logic             w1_o,
  output logic [POS_W-1:0] pos1_o,
  output logic             stop_o,
  output logic             ovf_hit_o,
  output logic [CNT_W-1:0] free_nxt_o
);

  logic term0, term1, cov0, cov1;
  assign term0 = f_is_term(y0_i);
  assign term1 = f_is_term(y1_i);
  assign cov0  = f_covers(y0_i, tline_i, tall_i);
  assign cov1  = f_covers(y1_i, tline_i, tall_i);

  always_comb begin
    logic [CNT_W-1:0] f;
    f         = free_i;
    w0_o      = 1'b0;
    w1_o      = 1'b0;
    pos0_o    = '0;
    pos1_o    = '0;
    stop_o    = 1'b0;
    ovf_hit_o = 1'b0;
    if (term0) begin
      stop_o = 1'b1;
    end else if (cov0) begin
      if (f == '0) begin
        ovf_hit_o = 1'b1;
        stop_o    = 1'b1;
      end else begin
        w0_o   = 1'b1;
        pos0_o = POS_W'(f - 1'b1);
        f      = f - 1'b1;
      end
    end
    if (!stop_o) begin
      if (term1) begin
        stop_o = 1'b1;
      end else if (cov1) begin
        if (f == '0) begin
          ovf_hit_o = 1'b1;
          stop_o    = 1'b1;
        end else begin
          w1_o   = 1'b1;
          pos1_o = POS_W'(f - 1'b1);
          f      = f - 1'b1;
        end
      end
    end
    free_nxt_o = f;
  end

  // R5: a terminating first byte blocks both writes
  p_term_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && y0_i >= TERM_Y) |-> (stop_o && !w0_o && !w1_o));

  // R6: overflow only comes with an empty free pool
  p_ovf_no_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && ovf_hit_o) |-> (free_nxt_o == '0));

endmodule

// File: rtl/sle_scan_ctrl.sv
module sle_scan_ctrl
  import sle_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int NENT  = 64,
  localparam int CNT_W = $clog2(NSLOT + 1),
  localparam int IDX_W = $clog2(NENT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               strobe_i,
  input  logic               ovf_clr_i,
  input  logic [6:0]         tbl_base_i,
  input  logic               ev_stop_i,
  input  logic               ev_ovf_i,
  input  logic [CNT_W-1:0]   ev_free_nxt_i,
  output logic               rd_en_o,
  output logic [VADDR_W-1:0] rd_addr_o,
  output logic               fire_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [CNT_W-1:0]   free_o,
  output logic               ovf_o,
  output logic               done_o
);

  localparam logic [IDX_W-1:0] LAST_PAIR = IDX_W'(NENT - 2);

  scan_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] free_q;
  logic             ovf_q;

  assign rd_en_o   = (state_q == ST_RUN) && strobe_i && !start_i;
  assign rd_addr_o = f_table_base(tbl_base_i) + VADDR_W'(idx_q);
  assign fire_o    = (state_q == ST_WAIT) && !start_i;
  assign idx_o     = idx_q;
  assign free_o    = free_q;
  assign ovf_o     = ovf_q;
  assign done_o    = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DONE;
      idx_q   <= '0;
      free_q  <= CNT_W'(NSLOT);
    end else if (start_i) begin
      state_q <= ST_RUN;
      idx_q   <= '0;
      free_q  <= CNT_W'(NSLOT);
    end else begin
      case (state_q)
        ST_RUN: if (strobe_i) state_q <= ST_WAIT;
        ST_WAIT: begin
          free_q <= ev_free_nxt_i;
          if (ev_stop_i || idx_q == LAST_PAIR) begin
            state_q <= ST_DONE;
          end else begin
            idx_q   <= idx_q + IDX_W'(2);
            state_q <= ST_RUN;
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovf_q <= 1'b0;
    else if (fire_o && ev_ovf_i) ovf_q <= 1'b1;
    else if (ovf_clr_i)          ovf_q <= 1'b0;
  end

  p_free_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_q <= CNT_W'(NSLOT));
  p_ovf_rise_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> (free_q == '0));
  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q);
  p_no_read_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_en_o);
  p_single_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);
  p_even_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (rd_addr_o[0] == 1'b0));
  p_start_init_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (free_q == CNT_W'(NSLOT) && idx_q == '0 && !done_o));

endmodule

// File: rtl/sle_slot_list.sv
module sle_slot_list #(
  parameter int NSLOT = 8,
  parameter int IDX_W = 6,
  localparam int POS_W = $clog2(NSLOT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               w0_i,
  input  logic [POS_W-1:0]   pos0_i,
  input  logic [IDX_W-1:0]   idx0_i,
  input  logic [7:0]         y0_i,
  input  logic               w1_i,
  input  logic [POS_W-1:0]   pos1_i,
  input  logic [IDX_W-1:0]   idx1_i,
  input  logic [7:0]         y1_i,
  output logic [NSLOT-1:0]       vld_o,
  output logic [NSLOT*IDX_W-1:0] idx_o,
  output logic [NSLOT*8-1:0]     y_o
);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic             vld_q;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       y_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        idx_q <= '0;
        y_q   <= '0;
      end else if (clr_i) begin
        vld_q <= 1'b0;
      end else if (w0_i && pos0_i == POS_W'(s)) begin
        vld_q <= 1'b1;
        idx_q <= idx0_i;
        y_q   <= y0_i;
      end else if (w1_i && pos1_i == POS_W'(s)) begin
        vld_q <= 1'b1;
        idx_q <= idx1_i;
        y_q   <= y1_i;
      end
    end

    assign vld_o[s]                = vld_q;
    assign idx_o[s*IDX_W +: IDX_W] = idx_q;
    assign y_o[s*8 +: 8]           = y_q;
  end

  // R4: one pair never targets the same slot twice
  p_distinct_slots_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w0_i && w1_i) |-> (pos0_i != pos1_i));

endmodule

// File: rtl/sprite_line_eval.sv
module sprite_line_eval
  import sle_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int NENT  = 64,
  localparam int CNT_W = $clog2(NSLOT + 1),
  localparam int POS_W = $clog2(NSLOT),
  localparam int IDX_W = $clog2(NENT)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [7:0]             line_i,
  input  logic [6:0]             tbl_base_i,
  input  logic                   tall_i,
  input  logic                   scan_start_i,
  input  logic                   scan_slot_i,
  input  logic                   stat_clr_i,
  output logic                   vram_rd_en_o,
  output logic [13:0]            vram_rd_addr_o,
  input  logic [15:0]            vram_rd_data_i,
  output logic [NSLOT-1:0]       slot_vld_o,
  output logic [NSLOT*IDX_W-1:0] slot_idx_o,
  output logic [NSLOT*8-1:0]     slot_y_o,
  output logic                   overflow_o,
  output logic                   scan_done_o
);

  logic             fire, stop, ovf_hit, w0, w1;
  logic [POS_W-1:0] pos0, pos1;
  logic [CNT_W-1:0] free_q, free_nxt;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       tline;

  assign tline = f_target_line(line_i);

  sle_scan_ctrl #(.NSLOT(NSLOT), .NENT(NENT)) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(scan_start_i),
    .strobe_i(scan_slot_i), .ovf_clr_i(stat_clr_i), .tbl_base_i(tbl_base_i),
    .ev_stop_i(stop), .ev_ovf_i(ovf_hit), .ev_free_nxt_i(free_nxt),
    .rd_en_o(vram_rd_en_o), .rd_addr_o(vram_rd_addr_o), .fire_o(fire),
    .idx_o(idx_q), .free_o(free_q), .ovf_o(overflow_o), .done_o(scan_done_o)
  );

  sle_pair_eval #(.NSLOT(NSLOT)) eval_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire),
    .y0_i(vram_rd_data_i[7:0]), .y1_i(vram_rd_data_i[15:8]),
    .tline_i(tline), .tall_i(tall_i), .free_i(free_q),
    .w0_o(w0), .pos0_o(pos0), .w1_o(w1), .pos1_o(pos1),
    .stop_o(stop), .ovf_hit_o(ovf_hit), .free_nxt_o(free_nxt)
  );

  sle_slot_list #(.NSLOT(NSLOT), .IDX_W(IDX_W)) list_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(scan_start_i),
    .w0_i(w0 && fire), .pos0_i(pos0), .idx0_i(idx_q), .y0_i(vram_rd_data_i[7:0]),
    .w1_i(w1 && fire), .pos1_i(pos1), .idx1_i(idx_q + IDX_W'(1)),
    .y1_i(vram_rd_data_i[15:8]),
    .vld_o(slot_vld_o), .idx_o(slot_idx_o), .y_o(slot_y_o)
  );

  // R4: valid slots and the free counter stay consistent
  p_vld_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(slot_vld_o) == (NSLOT - int'(free_q)));

endmodule

// File: tb/sprite_line_eval_tb_top.sv
module sprite_line_eval_tb_top;

  localparam int NS = 8;
  localparam int NE = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  line = '0;
  logic [6:0]  base = '0;
  logic        tall = 1'b0;
  logic        start = 1'b0, slot = 1'b0, clr = 1'b0;
  logic        rd_en;
  logic [13:0] rd_addr;
  logic [15:0] rd_data = '0;
  logic [NS-1:0]   vld;
  logic [NS*6-1:0] sidx;
  logic [NS*8-1:0] sy;
  logic        ovf, done;

  always #4 clk = ~clk;

  sprite_line_eval dut_i (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .tbl_base_i(base), .tall_i(tall),
    .scan_start_i(start), .scan_slot_i(slot), .stat_clr_i(clr),
    .vram_rd_en_o(rd_en), .vram_rd_addr_o(rd_addr), .vram_rd_data_i(rd_data),
    .slot_vld_o(vld), .slot_idx_o(sidx), .slot_y_o(sy),
    .overflow_o(ovf), .scan_done_o(done)
  );

  logic [7:0] tbl [NE];
  int rd_cnt = 0, addr_err = 0;
  int n_chk = 0, n_fail = 0;

  // memory model: table lives at the base page, one cycle read latency
  always @(posedge clk) begin
    if (rd_en) begin
      if (rd_addr[13:8] != base[6:1] || int'(rd_addr[7:0]) != 2 * rd_cnt)
        addr_err++;
      rd_data <= {tbl[(rd_addr[5:0] + 6'd1)], tbl[rd_addr[5:0]]};
      rd_cnt++;
    end
  end

  // expected model
  logic [NS-1:0] e_vld;
  int  e_idx [NS];
  int  e_y   [NS];
  int  e_reads;
  logic e_ovf = 1'b0;

  function automatic bit covers_m(int y, int ln, bit tl);
    int t, d;
    t = (ln + 1) % 256;
    d = t - y;
    return d >= 0 && d < (tl ? 16 : 8);
  endfunction

  task automatic model();
    int free_n = NS;
    int stop_at = -1;
    e_vld = '0;
    for (int k = 0; k < NE; k++) begin
      if (stop_at < 0) begin
        if (int'(tbl[k]) >= 208) stop_at = k;
        else if (covers_m(int'(tbl[k]), int'(line), tall)) begin
          if (free_n == 0) begin e_ovf = 1'b1; stop_at = k; end
          else begin
            free_n--;
            e_vld[free_n] = 1'b1;
            e_idx[free_n] = k;
            e_y[free_n]   = int'(tbl[k]);
          end
        end
      end
    end
    e_reads = (stop_at < 0) ? NE / 2 : stop_at / 2 + 1;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_scan(string req);
    model();
    rd_cnt = 0; addr_err = 0;
    pulse_start();
    chk(vld == '0 && !done, "R9", int'(vld), 0);
    slot = 1'b1;
    repeat (80) @(negedge clk);
    slot = 1'b0;
    @(negedge clk);
    chk(done, "R8", int'(done), 1);
    chk(rd_cnt == e_reads, {req, " R2 reads"}, rd_cnt, e_reads);
    chk(addr_err == 0, "R2 address", addr_err, 0);
    chk(vld == e_vld, {req, " R4 valid"}, int'(vld), int'(e_vld));
    for (int s = 0; s < NS; s++) if (e_vld[s]) begin
      chk(int'(sidx[s*6 +: 6]) == e_idx[s], {req, " R4 index"}, int'(sidx[s*6 +: 6]), e_idx[s]);
      chk(int'(sy[s*8 +: 8]) == e_y[s], {req, " R4 y"}, int'(sy[s*8 +: 8]), e_y[s]);
    end
    chk(ovf == e_ovf, {req, " R6/R7 overflow"}, int'(ovf), int'(e_ovf));
  endtask

  task automatic fill(int v);
    for (int k = 0; k < NE; k++) tbl[k] = 8'(v);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    e_ovf = 1'b0;
    chk(!ovf, "R7 clear", int'(ovf), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED1234);
    fill(8'hE0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(vld == '0 && !ovf && done && !rd_en, "R10", int'({vld, ovf, done, rd_en}), 2);
    slot = 1'b1; rd_cnt = 0;
    repeat (4) @(negedge clk);
    slot = 1'b0;
    chk(rd_cnt == 0, "R10 no reads", rd_cnt, 0);

    // R5: immediate terminator
    base = 7'h2B; line = 8'd40;
    run_scan("R5 empty");

    // R1: wrap, line 255 targets line 0
    fill(8'hC0); line = 8'd255; tbl[0] = 8'd0; tbl[1] = 8'hFF;
    run_scan("R1 wrap");

    // R3: height boundaries, target 100
    fill(8'hC0); line = 8'd99;
    tbl[0] = 8'd93; tbl[1] = 8'd92; tbl[2] = 8'd85; tbl[3] = 8'd84; tbl[4] = 8'hD0;
    tall = 1'b0; run_scan("R3 short");
    tall = 1'b1; run_scan("R3 tall");
    tall = 1'b0;

    // R4/R6: exactly eight covering, no overflow
    fill(8'hC0); line = 8'd49;
    for (int k = 0; k < 8; k++) tbl[k * 3] = 8'(45 + k % 4);
    tbl[30] = 8'hD8;
    run_scan("R6 eight");

    // R6: nine covering, overflow and early stop
    tbl[24] = 8'd50;
    run_scan("R6 nine");
    // R7: sticky across a clean scan
    fill(8'hE5);
    run_scan("R7 sticky");
    do_clear();

    // R5: terminator on second byte after a match
    fill(8'hC0); line = 8'd10; tbl[0] = 8'd11; tbl[1] = 8'hD5; tbl[2] = 8'd11;
    run_scan("R5 odd");
    // R5: terminator first byte, covering second ignored
    tbl[0] = 8'hD1; tbl[1] = 8'd11;
    run_scan("R5 first");

    // R8: full table without terminator, then extra strobes
    fill(8'h20); line = 8'd200;
    run_scan("R8 full");
    rd_cnt = 0; slot = 1'b1;
    repeat (10) @(negedge clk);
    slot = 1'b0;
    chk(rd_cnt == 0, "R8 idle strobes", rd_cnt, 0);

    // R9: restart mid-scan
    fill(8'hC0); line = 8'd60; tbl[0] = 8'd58; tbl[5] = 8'd61; tbl[9] = 8'hD0;
    pulse_start();
    slot = 1'b1; repeat (3) @(negedge clk); slot = 1'b0;
    run_scan("R9 restart");

    // random scans
    for (int n = 0; n < 40; n++) begin
      line = 8'($urandom_range(0, 255));
      base = 7'($urandom_range(0, 127));
      tall = 1'($urandom_range(0, 1));
      for (int k = 0; k < NE; k++) begin
        if ($urandom_range(0, 39) == 0) tbl[k] = 8'($urandom_range(208, 255));
        else tbl[k] = 8'((int'(line) + 300 - $urandom_range(0, 60)) % 256);
      end
      run_scan("random");
      if (ovf && $urandom_range(0, 1) == 1) do_clear();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule